// File: doc/BRIEF.md
# Redundant Output Agreement Monitor

This block supervises a bank of switched outputs driven by two independent computing channels. The primary channel supplies the command that is actually applied. The secondary channel works out the same command by its own means and only checks it. At every main tick, once both channels have presented their values, the monitor compares the two commands. It also compares the digital readback of each output with the value that was driven during the tick period just ended.

While everything agrees, the monitor asserts a master enable that gates power to the whole bank, and it passes the primary command to the per-output enables. A command disagreement at a tick is fatal at once. A readback disagreement is tolerated for a configurable number of consecutive ticks, so that switching edges do not cause a trip. After that number of ticks the monitor trips. A trip latches a safe state that drops the master enable and forces every individual enable low. Only a reset clears it.

Top module: `out_agree_mon`

## Requirements
- R1: During and after reset, before any tick, `master_en_o` is 0, `out_en_o` is all zeros and `safe_o` is 0.
- R2: On a tick where the two commands are equal and no readback trip occurs, `master_en_o` becomes 1 and `out_en_o` takes the value of `pri_cmd_i`. The outputs change on the clock edge that samples `tick_i` high.
- R3: If `pri_cmd_i` differs from `sec_cmd_i` in any bit at a tick, the edge that samples the tick sets `safe_o` to 1, `master_en_o` to 0 and `out_en_o` to zero. This also applies on the very first tick after reset.
- R4: At each tick, bit i of `rdbk_i` is compared with `out_en_o[i]` as it was driven before that tick. A mismatch on RB_TOL consecutive ticks (default 2) is tolerated. A mismatch on the next consecutive tick (RB_TOL+1) trips safe state as in R3.
- R5: Each output has its own run count of mismatching ticks. A tick where that output's readback matches clears its count. Mismatches on different outputs do not add up.
- R6: Between ticks, the command and readback inputs have no effect: `master_en_o`, `out_en_o` and `safe_o` hold their values.
- R7: Safe state is latched. Later ticks with agreeing commands and a clean readback leave `safe_o` at 1 and all enables at 0 until reset.
- R8: When a readback trip falls on the same tick as a change in the command, the trip wins. All enables go to 0 and the new command is never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe marking the main tick compare point |
| pri_cmd_i | input | N_OUT | Output command from the primary channel |
| sec_cmd_i | input | N_OUT | Output command from the secondary channel |
| rdbk_i | input | N_OUT | Digitised readback of each output |
| master_en_o | output | 1 | Master enable gating power to all outputs |
| out_en_o | output | N_OUT | Per-output enables |
| safe_o | output | 1 | High once safe state is latched |

## Verification
Two functions can fall on one tick. The first is the readback filter expiring on an output. The second is the command path loading a new, agreeing command. This is provoked by holding the readback of one output wrong for RB_TOL ticks and then presenting a changed command on the next tick with the same readback fault. The result is judged by requiring all enables to drop rather than taking the new command. The same situation also shows that the readback of a tick is judged against the old applied value and not the incoming one. A scoreboard model built from the requirements predicts the outputs after every tick.

// File: rtl/aom_pkg.sv
package aom_pkg;

   // Supervisor phase: waiting for the first clean tick, running, or latched safe.
   typedef enum logic [1:0] {
      MS_IDLE = 2'd0,
      MS_RUN  = 2'd1,
      MS_SAFE = 2'd2
   } mon_state_t;

endpackage

// File: rtl/aom_cmd_cmp.sv
module aom_cmd_cmp #(
   parameter int N_OUT = 14
) (
   input  logic             tick_i,
   input  logic [N_OUT-1:0] a_i,
   input  logic [N_OUT-1:0] b_i,
   output logic             mis_o
);

   logic [N_OUT-1:0] diff;

   assign diff  = a_i ^ b_i;
   assign mis_o = tick_i & (|diff);

endmodule

// File: rtl/aom_rb_filter.sv
module aom_rb_filter #(
   parameter int N_OUT  = 14,
   parameter int RB_TOL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [N_OUT-1:0] applied_i,
   input  logic [N_OUT-1:0] rdbk_i,
   output logic             trip_o
);

   logic [N_OUT-1:0] trip_v;

   for (genvar gi = 0; gi < N_OUT; gi++) begin : g_bit
      logic mis;
      assign mis = applied_i[gi] ^ rdbk_i[gi];

      if (RB_TOL == 0) begin : g_direct
         assign trip_v[gi] = tick_i & mis;
      end else begin : g_count
         localparam int CNT_W = (RB_TOL < 2) ? 1 : $clog2(RB_TOL + 1);
         localparam logic [CNT_W-1:0] TOL_C = CNT_W'(RB_TOL);
         logic [CNT_W-1:0] cnt_q;

         // run length of consecutive mismatching ticks, saturating at the limit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (tick_i) begin
               if (!mis) begin
                  cnt_q <= '0;
               end else if (cnt_q != TOL_C) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         assign trip_v[gi] = tick_i & mis & (cnt_q == TOL_C);
      end
   end

   assign trip_o = |trip_v;

endmodule

// File: rtl/aom_out_stage.sv
module aom_out_stage
   import aom_pkg::*;
#(
   parameter int N_OUT = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [N_OUT-1:0] pri_cmd_i,
   input  logic             cmd_mis_i,
   input  logic             rb_trip_i,
   output logic             master_en_o,
   output logic [N_OUT-1:0] out_en_o,
   output logic             safe_o
);

   mon_state_t       state_q;
   logic [N_OUT-1:0] en_q;
   logic             run;
   logic             fault;

   assign fault = cmd_mis_i | rb_trip_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MS_IDLE;
         en_q    <= '0;
      end else if (tick_i && (state_q != MS_SAFE)) begin
         if (fault) begin
            state_q <= MS_SAFE;
            en_q    <= '0;
         end else begin
            state_q <= MS_RUN;
            en_q    <= pri_cmd_i;
         end
      end
   end

   assign run         = (state_q == MS_RUN);
   assign master_en_o = run;
   assign out_en_o    = en_q & {N_OUT{run}};
   assign safe_o      = (state_q == MS_SAFE);

endmodule

// File: rtl/out_agree_mon.sv
module out_agree_mon #(
   parameter int N_OUT  = 14,
   parameter int RB_TOL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [N_OUT-1:0] pri_cmd_i,
   input  logic [N_OUT-1:0] sec_cmd_i,
   input  logic [N_OUT-1:0] rdbk_i,
   output logic             master_en_o,
   output logic [N_OUT-1:0] out_en_o,
   output logic             safe_o
);

   if (N_OUT < 1 || N_OUT > 64) begin : g_bad_width
      $error("out_agree_mon: N_OUT must lie in 1..64");
   end
   if (RB_TOL < 0 || RB_TOL > 1023) begin : g_bad_tol
      $error("out_agree_mon: RB_TOL must lie in 0..1023");
   end

   logic cmd_mis;
   logic rb_trip;

   aom_cmd_cmp #(.N_OUT(N_OUT)) u_cmp (
      .tick_i (tick_i),
      .a_i    (pri_cmd_i),
      .b_i    (sec_cmd_i),
      .mis_o  (cmd_mis)
   );

   aom_rb_filter #(.N_OUT(N_OUT), .RB_TOL(RB_TOL)) u_rbf (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .applied_i (out_en_o),
      .rdbk_i    (rdbk_i),
      .trip_o    (rb_trip)
   );

   aom_out_stage #(.N_OUT(N_OUT)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .pri_cmd_i   (pri_cmd_i),
      .cmd_mis_i   (cmd_mis),
      .rb_trip_i   (rb_trip),
      .master_en_o (master_en_o),
      .out_en_o    (out_en_o),
      .safe_o      (safe_o)
   );

endmodule

// File: rtl/aom_chk.sv
module aom_chk #(
   parameter int N_OUT = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic [N_OUT-1:0] pri_cmd_i,
   input logic [N_OUT-1:0] sec_cmd_i,
   input logic             master_en_o,
   input logic [N_OUT-1:0] out_en_o,
   input logic             safe_o
);

   // R3
   cmd_mis_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && (pri_cmd_i != sec_cmd_i)) |=> (safe_o && !master_en_o && (out_en_o == '0)));

   // R3
   safe_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      safe_o |-> (!master_en_o && (out_en_o == '0)));

   // R7
   safe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      safe_o |=> safe_o);

   // R6
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(out_en_o) && $stable(master_en_o) && $stable(safe_o)));

   // R2
   follow_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> (!master_en_o || (out_en_o == $past(pri_cmd_i))));

endmodule

bind out_agree_mon aom_chk #(.N_OUT(N_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .pri_cmd_i   (pri_cmd_i),
   .sec_cmd_i   (sec_cmd_i),
   .master_en_o (master_en_o),
   .out_en_o    (out_en_o),
   .safe_o      (safe_o)
);

// File: tb/out_agree_mon_tb.sv
`timescale 1ns/1ps
module out_agree_mon_tb;

   localparam int N   = 14;
   localparam int TOL = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_i = 1'b0;
   logic [N-1:0] pri = '0;
   logic [N-1:0] sec = '0;
   logic [N-1:0] rb  = '0;
   logic         master_en;
   logic [N-1:0] out_en;
   logic         safe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // scoreboard: {safe, master, enables}
   logic [N+1:0] exp_q[$];
   string        tag_q[$];

   // reference model state
   int           m_state;   // 0 idle, 1 run, 2 safe
   logic [N-1:0] m_en;
   int           m_cnt[N];

   always #5 clk = ~clk;

   out_agree_mon #(.N_OUT(N), .RB_TOL(TOL)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .pri_cmd_i(pri), .sec_cmd_i(sec), .rdbk_i(rb),
      .master_en_o(master_en), .out_en_o(out_en), .safe_o(safe)
   );

   task automatic check(input string tag, input logic [N+1:0] act, input logic [N+1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [N+1:0] model_out();
      logic [N-1:0] en;
      en = (m_state == 1) ? m_en : '0;
      return {(m_state == 2), (m_state == 1), en};
   endfunction

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0; tick_i = 1'b0; pri = '0; sec = '0; rb = '0;
      m_state = 0; m_en = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
      repeat (3) @(negedge clk);
      check({tag, " in reset"}, {safe, master_en, out_en}, model_out());
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({tag, " after reset"}, {safe, master_en, out_en}, model_out());
   endtask

   task automatic do_tick(input logic [N-1:0] p, input logic [N-1:0] s,
                          input logic [N-1:0] r, input string tag);
      logic [N-1:0] applied;
      bit trip;
      applied = (m_state == 1) ? m_en : '0;
      trip = 1'b0;
      if (m_state != 2) begin
         for (int i = 0; i < N; i++) begin
            if (applied[i] != r[i]) begin
               if (m_cnt[i] == TOL) trip = 1'b1;
               else m_cnt[i]++;
            end else begin
               m_cnt[i] = 0;
            end
         end
         if (trip || (p != s)) begin
            m_state = 2; m_en = '0;
         end else begin
            m_state = 1; m_en = p;
         end
      end
      exp_q.push_back(model_out());
      tag_q.push_back(tag);
      @(negedge clk);
      pri = p; sec = s; rb = r; tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
   endtask

   // monitor: judge the outputs just after each edge that samples a tick
   initial begin
      forever begin
         @(posedge clk);
         if (tick_i === 1'b1) begin
            #2;
            if (exp_q.size() == 0) begin
               n_tests++; n_fail++;
               $display("FAIL scoreboard: result without expectation");
            end else begin
               check(tag_q.pop_front(), {safe, master_en, out_en}, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   localparam logic [N-1:0] A  = 14'h1A5C;
   localparam logic [N-1:0] B  = 14'h0F0F;
   localparam logic [N-1:0] B3 = 14'h0008;
   localparam logic [N-1:0] BT = 14'h2000;

   initial begin
      // R1 reset state
      do_reset("R1 seq1");
      do_tick(A, A, '0, "R2 first clean tick applies command");
      do_tick(B, B, A, "R2 command change with old readback");

      // R6 inputs between ticks have no effect
      @(negedge clk);
      pri = A; sec = ~A; rb = 14'h3FFF;
      repeat (6) @(negedge clk);
      check("R6 no tick, disagreeing inputs", {safe, master_en, out_en}, model_out());

      do_tick(B, B, B ^ B3, "R4 readback mismatch tick 1 tolerated");
      do_tick(B, B, B ^ B3, "R4 readback mismatch tick 2 tolerated");
      do_tick(B, B, B, "R5 matching tick clears count");
      do_tick(B, B, B ^ B3, "R5 after clear, mismatch 1");
      do_tick(B, B, B ^ B3, "R5 after clear, mismatch 2");
      do_tick(B, B, B ^ B3, "R4 third consecutive mismatch trips");
      do_tick(A, A, '0, "R7 safe stays latched");
      do_tick(B, B, '0, "R7 safe stays latched again");

      do_reset("R1 seq2 after safe");
      do_tick(A, A, '0, "R2 run again");
      do_tick(A, A, A ^ 14'h0001, "R5 bit0 mismatch");
      do_tick(A, A, A ^ 14'h0002, "R5 bit1 mismatch");
      do_tick(A, A, A ^ 14'h0001, "R5 bit0 mismatch again");
      do_tick(A, A, A ^ 14'h0002, "R5 bit1 mismatch again");
      do_tick(A, A ^ BT, A, "R3 top bit command mismatch");

      do_reset("R1 seq3");
      do_tick(A, A, '0, "R2 run for coincidence");
      do_tick(A, A, A ^ BT, "R8 top bit readback mismatch 1");
      do_tick(A, A, A ^ BT, "R8 top bit readback mismatch 2");
      do_tick(B, B, A ^ BT, "R8 trip wins over command change");

      do_reset("R1 seq4");
      do_tick(A, A ^ 14'h0001, '0, "R3 mismatch on first tick");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL scoreboard: %0d results missing, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule